// File: doc/BRIEF.md
# Smart Card Character Transmitter with Card Clock Control

This block sends single characters over the half-duplex data line of an ISO 7816-style smart card link and generates the card clock. A character is a low start bit, eight data bits sent least significant bit first, and an even parity bit. Each bit lasts one elementary time unit (etu). The etu length is given in system clock cycles on a divisor input. The divisor is captured together with the mode select when a byte is written. After the parity bit the line returns high and stays there through the guard time.

A transmit-end flag tells the host when the link may be used again. Its timing depends on the mode select. In normal mode it rises 12.5 etu after the start bit begins. In GSM mode it rises after 11.0 etu. Writing a new byte clears the flag.

The card clock runs from a free divider at a fixed half-period of `CK_HALF` system cycles. Two control bits start and stop it. In normal mode they only switch it on, or off with the pin held low. In GSM mode a stopped clock can be parked either high or low. In both modes the pin changes only on a divider boundary and only in step with the divider phase, so no high or low level is ever cut short.

Top module: `sc_tx`

## Requirements
- R1: After reset `txd_o` is 1, `tend_o` is 1, `sck_o` is 0 and no character is in progress.
- R2: While `en_i` is 0, a write does not start a character. Clearing `en_i` during a character aborts it, and `txd_o` is 1 from the next cycle. `tend_o` keeps its value.
- R3: A write is accepted when `wr_i` and `en_i` are 1 and no character is in progress. It clears `tend_o` in the next cycle. That next cycle is cycle c=0 of the character. For c in [k*D, (k+1)*D), `txd_o` carries bit k. Bit 0 is the start bit (0), bits 1..8 are `data_i[0]`..`data_i[7]`, bit 9 is parity, and `txd_o` is 1 from c=10*D on.
- R4: The parity bit equals the XOR of the eight data bits (even parity).
- R5: In normal mode (`gsm_i`=0 at the write), `tend_o` first reads 1 at c = 12*D + floor(D/2). The character ends in that same cycle.
- R6: In GSM mode (`gsm_i`=1 at the write), `tend_o` first reads 1 at c = 11*D.
- R7: A write while a character is in progress is ignored. This includes the last cycle before `tend_o` rises.
- R8: D is `etu_div_i` captured at the accepted write, with values below 2 taken as 2. Later changes to `etu_div_i` and `gsm_i` do not affect the current character's timing.
- R9: With `ckc_i[0]`=1 the card clock toggles once every `CK_HALF` system cycles.
- R10: In normal mode, `ckc_i[0]`=0 stops the card clock at low level, and `ckc_i[1]` has no effect.
- R11: In GSM mode, `ckc_i[0]`=0 parks the card clock at the level of `ckc_i[1]`.
- R12: `sck_o` changes only on a divider boundary. Every high and every low level on `sck_o` lasts at least `CK_HALF` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Smart card function enable |
| gsm_i | input | 1 | Mode select: 0 normal, 1 GSM |
| ckc_i | input | 2 | Card clock control: [0] run, [1] park level (GSM only) |
| etu_div_i | input | DIV_W | System cycles per etu |
| data_i | input | 8 | Byte to send |
| wr_i | input | 1 | Write strobe |
| txd_o | output | 1 | Serial data line, idles high |
| sck_o | output | 1 | Card clock |
| tend_o | output | 1 | Transmit-end flag |

## Verification
Two pairs of events can land in the same cycle. The first pair is a host write and the character's end point. The bench strobes `wr_i` in the final busy cycle and expects `tend_o` to rise and the line to stay idle, with no new start bit. The second pair is a clock-control change and a card clock divider boundary. The bench flips `ckc_i` and `gsm_i` on every cycle for a stretch. A cycle-level model then compares `sck_o` on each clock, and every level on the pin is timed against `CK_HALF`.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_SEND = 1'b1} tx_state_e;

  localparam int unsigned FRAME_BITS   = 10;
  localparam int unsigned IDX_W        = 4;
  localparam int unsigned NRM_LAST_IDX = 12;
  localparam int unsigned GSM_LAST_IDX = 10;

  function automatic logic even_par(input logic [7:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/sc_tx_etu.sv
module sc_tx_etu #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic [IDX_W-1:0] idx_o
);
  logic last;
  assign last = (cnt_o == div_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      idx_o <= '0;
    end else if (load_i) begin
      cnt_o <= '0;
      idx_o <= '0;
    end else if (run_i) begin
      if (last) begin
        cnt_o <= '0;
        if (idx_o != '1) idx_o <= idx_o + 1'b1;
      end else begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sc_tx_frame.sv
module sc_tx_frame
  import sc_tx_pkg::*;
#(
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [7:0]    data_i,
  input  logic          active_i,
  input  logic [IW-1:0] idx_i,
  output logic          txd_o
);
  logic [FRAME_BITS-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frame_q <= '1;
    else if (load_i) frame_q <= {even_par(data_i), data_i, 1'b0};
  end

  always_comb begin
    txd_o = 1'b1;
    for (int i = 0; i < FRAME_BITS; i++) begin
      if (active_i && (idx_i == IW'(i))) txd_o = frame_q[i];
    end
  end
endmodule

// File: rtl/sc_tx_ckgen.sv
module sc_tx_ckgen #(
  parameter int unsigned HALF = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       gsm_i,
  input  logic [1:0] ckc_i,
  output logic       sck_o,
  output logic       tick_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] div_q;
  logic          ph_q;
  logic          nph, run, park, tgt;

  assign tick_o = (div_q == CW'(HALF - 1));
  assign run    = ckc_i[0];
  assign park   = gsm_i & ckc_i[1];  // normal mode parks low only
  assign nph    = ~ph_q;
  assign tgt    = run ? nph : park;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ph_q  <= 1'b0;
      sck_o <= 1'b0;
    end else if (tick_o) begin
      div_q <= '0;
      ph_q  <= nph;
      // move only when the phase reaches the wanted level
      if (tgt == nph) sck_o <= nph;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/sc_tx.sv
module sc_tx
  import sc_tx_pkg::*;
#(
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned CK_HALF = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             gsm_i,
  input  logic [1:0]       ckc_i,
  input  logic [DIV_W-1:0] etu_div_i,
  input  logic [7:0]       data_i,
  input  logic             wr_i,
  output logic             txd_o,
  output logic             sck_o,
  output logic             tend_o
);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  tx_state_e        state_q;
  logic [DIV_W-1:0] div_q, cnt, half_m1;
  logic [IDX_W-1:0] idx;
  logic             gsm_q, tend_q, busy, accept, end_hit, ck_tick;

  assign busy    = (state_q == ST_SEND);
  assign accept  = en_i && wr_i && !busy;
  assign half_m1 = (div_q >> 1) - 1'b1;
  assign end_hit = busy && (gsm_q
                   ? (idx == IDX_W'(GSM_LAST_IDX) && cnt == div_q - 1'b1)
                   : (idx == IDX_W'(NRM_LAST_IDX) && cnt == half_m1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      div_q   <= DIV_MIN;
      gsm_q   <= 1'b0;
      tend_q  <= 1'b1;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
    end else if (accept) begin
      state_q <= ST_SEND;
      div_q   <= (etu_div_i < DIV_MIN) ? DIV_MIN : etu_div_i;
      gsm_q   <= gsm_i;
      tend_q  <= 1'b0;
    end else if (end_hit) begin
      state_q <= ST_IDLE;
      tend_q  <= 1'b1;
    end
  end

  assign tend_o = tend_q;

  sc_tx_etu #(.DIV_W(DIV_W), .IDX_W(IDX_W)) u_etu (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .run_i  (busy),
    .div_i  (div_q),
    .cnt_o  (cnt),
    .idx_o  (idx)
  );

  sc_tx_frame #(.IW(IDX_W)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .data_i   (data_i),
    .active_i (busy),
    .idx_i    (idx),
    .txd_o    (txd_o)
  );

  sc_tx_ckgen #(.HALF(CK_HALF)) u_ck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gsm_i  (gsm_i),
    .ckc_i  (ckc_i),
    .sck_o  (sck_o),
    .tick_o (ck_tick)
  );
endmodule

// File: rtl/sc_tx_chk.sv
module sc_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       wr_i,
  input logic       gsm_i,
  input logic [1:0] ckc_i,
  input logic       txd_o,
  input logic       sck_o,
  input logic       tend_o,
  input logic       busy_i,
  input logic       ck_tick_i
);
  a_r2_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (txd_o && !busy_i));

  a_r3_write_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_i && !busy_i) |=> (busy_i && !txd_o && !tend_o));

  a_r5_tend_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tend_o) |-> $past(busy_i));

  a_r5_tend_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && tend_o && !(en_i && wr_i)) |=> tend_o);

  a_r10_normal_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gsm_i && !ckc_i[0] && !sck_o) |=> !sck_o);

  a_r11_gsm_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gsm_i && !ckc_i[0] && (sck_o == ckc_i[1])) |=> (sck_o == $past(sck_o)));

  a_r12_sck_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sck_o) |-> $past(ck_tick_i));
endmodule

bind sc_tx sc_tx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .wr_i      (wr_i),
  .gsm_i     (gsm_i),
  .ckc_i     (ckc_i),
  .txd_o     (txd_o),
  .sck_o     (sck_o),
  .tend_o    (tend_o),
  .busy_i    (busy),
  .ck_tick_i (ck_tick)
);

// File: tb/sc_tx_test.sv
`timescale 1ns/1ps
module sc_tx_test;
  localparam int DIV_W = 16;
  localparam int HALF  = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, gsm = 1'b0, wr = 1'b0;
  logic [1:0] ckc = 2'b01;
  logic [DIV_W-1:0] div = 16'd8;
  logic [7:0] data = 8'h00;
  logic txd, sck, tend;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sc_tx #(.DIV_W(DIV_W), .CK_HALF(HALF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .gsm_i(gsm), .ckc_i(ckc),
    .etu_div_i(div), .data_i(data), .wr_i(wr),
    .txd_o(txd), .sck_o(sck), .tend_o(tend)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_busy, m_tend, m_gsm, m_sck, m_ph;
  int m_c, m_d, m_ckcnt;
  logic [9:0] m_frame;

  function automatic int m_end();
    return m_gsm ? 11 * m_d : 12 * m_d + m_d / 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_tend = 1; m_gsm = 0; m_c = 0; m_d = 2; m_frame = '1;
      m_sck = 0; m_ph = 0; m_ckcnt = 0;
    end else begin
      if (!en) m_busy = 0;
      else if (!m_busy) begin
        if (wr) begin
          m_busy = 1; m_c = 0; m_tend = 0; m_gsm = gsm;
          m_d = (div < 2) ? 2 : int'(div);
          m_frame = {^data, data, 1'b0};
        end
      end else if (m_c == m_end() - 1) begin
        m_busy = 0; m_tend = 1;
      end else m_c++;
      if (m_ckcnt == HALF - 1) begin
        bit np, tg;
        m_ckcnt = 0; np = !m_ph; m_ph = np;
        tg = ckc[0] ? np : (gsm & ckc[1]);
        if (tg == np) m_sck = np;
      end else m_ckcnt++;
    end
  end

  function automatic bit m_txd();
    if (m_busy && m_c < 10 * m_d) return m_frame[m_c / m_d];
    return 1'b1;
  endfunction

  bit cmp_en = 0;
  logic last_sck = 0;
  int run_len = 1000;
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk(txd == m_txd(), "R3 txd", txd, m_txd());
      chk(tend == m_tend, "R5 tend", tend, m_tend);
      chk(sck == m_sck, "R9 sck", sck, m_sck);
      if (sck != last_sck) begin
        chk(run_len >= HALF, "R12 level width", run_len, HALF);
        run_len = 1;
      end else run_len++;
      last_sck = sck;
    end
  end

  task automatic send(input logic [7:0] d, input logic g, input int dv,
                      input int inj, output int t);
    int de, k;
    de = (dv < 2) ? 2 : dv;
    @(negedge clk); data = d; gsm = g; div = DIV_W'(dv); wr = 1;
    @(negedge clk); wr = 0; div = 16'd9; k = 0;
    chk(txd == 1'b0, "R3 start bit", txd, 0);
    chk(tend == 1'b0, "R3 tend cleared", tend, 0);
    while (!tend && k < 3000) begin
      if (k >= de && k < 9 * de && (k % de) == de / 2)
        chk(txd == d[k / de - 1], "R3 data lsb first", txd, d[k / de - 1]);
      if (k == 9 * de + de / 2) chk(txd == ^d, "R4 parity", txd, ^d);
      if (k == inj) begin wr = 1; data = ~d; end
      @(negedge clk); wr = 0; k++;
    end
    t = k;
  endtask

  initial begin
    int t, n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1, "R1 txd", txd, 1);
    chk(tend == 1, "R1 tend", tend, 1);
    chk(sck == 0, "R1 sck", sck, 0);
    cmp_en = 1;

    send(8'hA5, 0, 8, -1, t);  chk(t == 100, "R5 normal end", t, 100);
    send(8'h3C, 1, 6, -1, t);  chk(t == 66, "R6 gsm end", t, 66);
    send(8'h01, 0, 5, 20, t);  chk(t == 62, "R7 mid-frame write", t, 62);
    send(8'hE7, 0, 0, -1, t);  chk(t == 25, "R8 divisor clamp", t, 25);
    send(8'h5A, 1, 7, 76, t);  chk(t == 77, "R7 write at end", t, 77);
    repeat (5) begin
      @(negedge clk);
      chk(tend == 1 && txd == 1, "R7 no restart", {tend, txd}, 3);
    end

    // R2 disabled write and abort
    en = 0; data = 8'h00; wr = 1; @(negedge clk); wr = 0;
    repeat (20) begin
      @(negedge clk);
      chk(txd == 1 && tend == 1, "R2 disabled", {txd, tend}, 3);
    end
    en = 1; data = 8'hFF; gsm = 0; div = 16'd4; wr = 1;
    @(negedge clk); wr = 0;
    repeat (15) @(negedge clk);
    en = 0; data = 8'h00;
    @(negedge clk);
    chk(txd == 1, "R2 abort", txd, 1);
    chk(tend == 0, "R2 tend kept", tend, 0);
    en = 1;
    send(8'h96, 0, 4, -1, t);  chk(t == 50, "R5 after abort", t, 50);

    // clock control
    gsm = 0; ckc = 2'b00; repeat (12) @(negedge clk);
    chk(sck == 0, "R10 off low", sck, 0);
    ckc = 2'b10; repeat (12) @(negedge clk);
    chk(sck == 0, "R10 park bit ignored", sck, 0);
    gsm = 1; ckc = 2'b10; repeat (12) @(negedge clk);
    chk(sck == 1, "R11 park high", sck, 1);
    ckc = 2'b00; repeat (12) @(negedge clk);
    chk(sck == 0, "R11 park low", sck, 0);
    ckc = 2'b01; repeat (10) @(negedge clk);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      logic s0;
      s0 = sck; @(negedge clk);
      if (sck != s0) n++;
    end
    chk(n == 60 / HALF, "R9 toggle rate", n, 60 / HALF);
    for (int i = 0; i < 80; i++) begin
      ckc = 2'(i * 7 % 4); gsm = 1'(i % 5 < 2);
      @(negedge clk);
    end
    ckc = 2'b01; gsm = 0;
    repeat (10) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule